// File: doc/BRIEF.md
# Serial-Access Static RAM Slave

This block is a synthesizable SPI slave that behaves as a byte-wide static RAM. It sits behind a four-wire serial link made of chip select, serial clock, serial data in and serial data out. A command opens with chip select going low. An 8-bit opcode follows, then a 16-bit address sent high byte first. After that the master either streams data bytes to be stored or clocks stored bytes back out. The address counter steps by one after every byte, so one command can cover any number of consecutive locations. Raising chip select ends or aborts the command, and the slave then waits for a new opcode.

The serial pins are oversampled in the block's own system clock. Each pin passes through a synchronizer chain, and the block acts on the rising and falling clock edges it detects. Mode 0 framing is used: the serial clock idles low, data in is sampled on rising edges, data out changes on falling edges, and every field is sent most significant bit first. The block provides a data-out value and a separate output enable, so the pad ring can place the tri-state buffer.

The protocol address is `ADDR_W` bits wide. Physical storage holds `2**STORE_AW` bytes. The full 64K map is reached with `STORE_AW = 16`. With a smaller store, the upper address bits are ignored.

Top module: `sram_spi_slave`

## Requirements
- R1: A write command stores each complete data byte at the current address. The command is opcode 0x02, then the address high byte, the address low byte, and the data byte or bytes.
- R2: A read command returns the stored byte on SO, most significant bit first. The command is opcode 0x03, then the two address bytes. Each bit is updated after a falling SCK edge, so it is stable when the next rising edge samples it.
- R3: In a write burst under one chip-select-low period, the n-th data byte goes to the start address plus n.
- R4: In a read burst under one chip-select-low period, the n-th returned byte comes from the start address plus n.
- R5: The address counter wraps from 0xFFFF to 0x0000 inside a burst.
- R6: An opcode other than 0x02 or 0x03 makes the slave ignore every following bit until chip select goes high. Nothing is stored and SO stays disabled.
- R7: A data byte cut short by chip select going high before its eighth bit is not stored.
- R8: The SO output enable is low whenever chip select is high. It is also low during the opcode and address phases and throughout write commands. It is high only while read data is being shifted out.
- R9: Chip select going high in the middle of an opcode or address aborts the command. The next chip-select-low period decodes its first 8 bits as a fresh opcode.
- R10: The storage holds 2**STORE_AW bytes, indexed by the low STORE_AW address bits. With STORE_AW = 10, addresses 0x0005 and 0x0405 name the same byte.
- R11: After reset the SO output enable is low and SO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master, idles low |
| spi_si | input | 1 | Serial data from the master |
| spi_so | output | 1 | Serial read data to the master |
| spi_so_oe | output | 1 | Output enable for the SO pad buffer |

## Verification
The bench builds the block with its default parameters: a 16-bit protocol address, a 1 KiB store (`STORE_AW = 10`) and two synchronizer stages. The small store puts the address aliasing at 0x0400 within reach of a short test. The 16-bit counter still makes the 0xFFFF to 0x0000 wrap visible within a two-byte burst. The bench runs the serial clock at eight system clocks per half period, which covers the synchronizer delay plus the one-cycle prefetch of the next read byte.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } cmd_state_e;

endpackage

// File: rtl/sram_spi_sync.sv
module sram_spi_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_n_o,
    output logic si_o,
    output logic sck_rise_o,
    output logic sck_fall_o
);

    // bit 2: chip select, bit 1: serial clock, bit 0: serial data
    localparam logic [2:0] IDLE_LEVELS = 3'b100;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        logic [2:0] lvl_q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lvl_q <= IDLE_LEVELS;
                else        lvl_q <= {cs_n_i, sck_i, si_i};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lvl_q <= IDLE_LEVELS;
                else        lvl_q <= g_stage[g-1].lvl_q;
            end
        end
    end

    logic [2:0] sync_lvl;
    logic       sck_prev_q;

    assign sync_lvl = g_stage[SYNC_STAGES-1].lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sync_lvl[1];
    end

    assign cs_n_o     = sync_lvl[2];
    assign si_o       = sync_lvl[0];
    assign sck_rise_o =  sync_lvl[1] & ~sck_prev_q;
    assign sck_fall_o = ~sync_lvl[1] &  sck_prev_q;

endmodule

// File: rtl/sram_spi_store.sv
module sram_spi_store #(
    parameter int ADDR_W   = 16,
    parameter int STORE_AW = 10,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 2 ** STORE_AW;

    logic [DATA_W-1:0] cell_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // only the low STORE_AW address bits select a cell
    always_ff @(posedge clk) begin
        if (wr_en) cell_q[STORE_AW'(wr_addr)] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= cell_q[STORE_AW'(rd_addr)];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/sram_spi_cmd.sv
module sram_spi_cmd
    import sram_spi_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              si_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              so,
    output logic              so_oe
);

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int BC_W       = $clog2(BYTE_W);
    localparam logic [AB_W-1:0] LAST_ABYTE = AB_W'(ADDR_BYTES - 1);
    localparam logic [BC_W-1:0] LAST_BIT   = BC_W'(BYTE_W - 1);

    typedef struct packed {
        cmd_state_e        state;
        logic              is_wr;
        logic [BYTE_W-2:0] sh;
        logic [BC_W-1:0]   bitcnt;
        logic [AB_W-1:0]   abyte;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] tx;
        logic              so;
        logic              oe;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } cmd_regs_t;

    localparam cmd_regs_t REGS_RESET = '{state: ST_OPCODE, default: '0};

    cmd_regs_t r_q, r_d;
    logic [BYTE_W-1:0] byte_in;
    logic              byte_done;

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        byte_in   = {r_q.sh, si_s};
        byte_done = (r_q.bitcnt == LAST_BIT);

        if (cs_n_s) begin
            // deselected: drop any partial field and release SO
            r_d.state  = ST_OPCODE;
            r_d.bitcnt = '0;
            r_d.abyte  = '0;
            r_d.oe     = 1'b0;
        end else begin
            if (sck_rise) begin
                r_d.sh     = byte_in[BYTE_W-2:0];
                r_d.bitcnt = byte_done ? '0 : r_q.bitcnt + 1'b1;
                if (byte_done) begin
                    unique case (r_q.state)
                        ST_OPCODE: begin
                            if (byte_in == OPC_WRITE) begin
                                r_d.state = ST_ADDR;
                                r_d.is_wr = 1'b1;
                            end else if (byte_in == OPC_READ) begin
                                r_d.state = ST_ADDR;
                                r_d.is_wr = 1'b0;
                            end else begin
                                r_d.state = ST_SKIP;
                            end
                        end
                        ST_ADDR: begin
                            r_d.addr = {r_q.addr[ADDR_W-BYTE_W-1:0], byte_in};
                            if (r_q.abyte == LAST_ABYTE) begin
                                r_d.abyte = '0;
                                r_d.state = r_q.is_wr ? ST_WDATA : ST_RDATA;
                            end else begin
                                r_d.abyte = r_q.abyte + 1'b1;
                            end
                        end
                        ST_WDATA: begin
                            r_d.wr_en   = 1'b1;
                            r_d.wr_addr = r_q.addr;
                            r_d.wr_data = byte_in;
                            r_d.addr    = r_q.addr + 1'b1;
                        end
                        ST_RDATA: begin
                            // step on so the store prefetches the next byte
                            r_d.addr = r_q.addr + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end

            if (sck_fall && r_q.state == ST_RDATA) begin
                r_d.oe = 1'b1;
                if (r_q.bitcnt == '0) begin
                    r_d.so = rd_data[BYTE_W-1];
                    r_d.tx = {rd_data[BYTE_W-2:0], 1'b0};
                end else begin
                    r_d.so = r_q.tx[BYTE_W-1];
                    r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RESET;
        else        r_q <= r_d;
    end

    assign rd_addr = r_q.addr;
    assign wr_en   = r_q.wr_en;
    assign wr_addr = r_q.wr_addr;
    assign wr_data = r_q.wr_data;
    assign so      = r_q.so;
    assign so_oe   = r_q.oe;

endmodule

// File: rtl/sram_spi_slave.sv
module sram_spi_slave
    import sram_spi_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int STORE_AW    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe
);

    logic              cs_n_s;
    logic              si_s;
    logic              sck_rise;
    logic              sck_fall;
    logic              mem_wr_en;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [BYTE_W-1:0] mem_wr_data;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [BYTE_W-1:0] mem_rd_data;

    sram_spi_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (spi_cs_n),
        .sck_i     (spi_sck),
        .si_i      (spi_si),
        .cs_n_o    (cs_n_s),
        .si_o      (si_s),
        .sck_rise_o(sck_rise),
        .sck_fall_o(sck_fall)
    );

    sram_spi_cmd #(
        .ADDR_W(ADDR_W)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (cs_n_s),
        .si_s    (si_s),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .rd_data (mem_rd_data),
        .rd_addr (mem_rd_addr),
        .wr_en   (mem_wr_en),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data),
        .so      (spi_so),
        .so_oe   (spi_so_oe)
    );

    sram_spi_store #(
        .ADDR_W  (ADDR_W),
        .STORE_AW(STORE_AW),
        .DATA_W  (BYTE_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mem_wr_en),
        .wr_addr(mem_wr_addr),
        .wr_data(mem_wr_data),
        .rd_addr(mem_rd_addr),
        .rd_data(mem_rd_data)
    );

endmodule

// File: rtl/sram_spi_checker.sv
module sram_spi_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_so,
    input logic              spi_so_oe,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);

    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (spi_cs_n) begin
            seen_q <= 1'b0;
        end else if (wr_en) begin
            seen_q <= 1'b1;
            last_q <= wr_addr;
        end
    end

    // R3 / R5: consecutive commits in one select period step by one, wrapping
    p_burst_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen_q && !spi_cs_n) |-> (wr_addr == last_q + 1'b1));

    // R8: a deselect held long enough to cross the synchronizer releases SO
    p_oe_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_so_oe);

    // R8: a commit to the store never happens while SO is driven
    p_no_wr_while_driving_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !spi_so_oe);

    // R6: the data line stays put while the buffer is disabled
    p_so_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_so_oe && !$past(spi_so_oe)) |-> $stable(spi_so));

    // R11: reset leaves the output buffer disabled
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_oe_r11: assert (!spi_so_oe);
        end
    end

endmodule

bind sram_spi_slave sram_spi_checker #(
    .ADDR_W(ADDR_W)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_so   (spi_so),
    .spi_so_oe(spi_so_oe),
    .wr_en    (mem_wr_en),
    .wr_addr  (mem_wr_addr)
);

// File: tb/sram_spi_slave_bench.sv
`timescale 1ns/1ps
module sram_spi_slave_bench;

    localparam int HALF = 8;
    localparam logic [7:0] OP_WR = 8'h02;
    localparam logic [7:0] OP_RD = 8'h03;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sck = 1'b0;
    logic spi_si = 1'b0;
    logic spi_so;
    logic spi_so_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sram_spi_slave u_sram_spi_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_si   (spi_si),
        .spi_so   (spi_so),
        .spi_so_oe(spi_so_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            spi_si = tx[7-i];
            repeat (HALF) @(negedge clk);
            rx = {rx[6:0], spi_so};
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic sel();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [15:0] a);
        logic [7:0] d;
        xfer(op, 8, d);
        xfer(a[15:8], 8, d);
        xfer(a[7:0], 8, d);
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel();
        send_hdr(OP_WR, a);
        xfer(v, 8, d);
        desel();
    endtask

    task automatic rd1(input logic [15:0] a, output logic [7:0] v);
        sel();
        send_hdr(OP_RD, a);
        xfer(8'h00, 8, v);
        desel();
    endtask

    task automatic t_reset();
        chk("R11 oe after reset", {7'd0, spi_so_oe}, 8'h00);
        chk("R11 so after reset", {7'd0, spi_so}, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] v;
        wr1(16'h1234, 8'hC5);
        rd1(16'h1234, v);
        chk("R1 R2 read back 0x1234", v, 8'hC5);
        wr1(16'h00FF, 8'h3A);
        rd1(16'h00FF, v);
        chk("R1 R2 read back 0x00FF", v, 8'h3A);
        rd1(16'h1234, v);
        chk("R1 earlier byte kept", v, 8'hC5);
    endtask

    task automatic t_burst();
        logic [7:0] d;
        logic [7:0] pat [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        sel();
        send_hdr(OP_WR, 16'h0040);
        for (int i = 0; i < 4; i++) xfer(pat[i], 8, d);
        desel();
        rd1(16'h0042, d);
        chk("R3 third burst byte at 0x0042", d, 8'hC3);
        rd1(16'h0043, d);
        chk("R3 fourth burst byte at 0x0043", d, 8'hD4);
        sel();
        send_hdr(OP_RD, 16'h0040);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h00, 8, d);
            chk($sformatf("R4 read burst byte %0d", i), d, pat[i]);
        end
        chk("R8 oe high in read data", {7'd0, spi_so_oe}, 8'h01);
        desel();
        chk("R8 oe low after deselect", {7'd0, spi_so_oe}, 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        sel();
        send_hdr(OP_WR, 16'hFFFF);
        xfer(8'h11, 8, d);
        xfer(8'h22, 8, d);
        desel();
        rd1(16'h0000, d);
        chk("R5 write wrapped to 0x0000", d, 8'h22);
        rd1(16'hFFFF, d);
        chk("R5 byte at 0xFFFF", d, 8'h11);
        sel();
        send_hdr(OP_RD, 16'hFFFF);
        xfer(8'h00, 8, d);
        xfer(8'h00, 8, d);
        desel();
        chk("R5 read wrapped to 0x0000", d, 8'h22);
    endtask

    task automatic t_bad_opcode();
        logic [7:0] d;
        wr1(16'h0200, 8'h3C);
        sel();
        xfer(8'h05, 8, d);
        xfer(OP_WR, 8, d);
        xfer(8'h02, 8, d);
        xfer(8'h00, 8, d);
        xfer(8'h99, 8, d);
        chk("R6 oe low after unknown opcode", {7'd0, spi_so_oe}, 8'h00);
        desel();
        rd1(16'h0200, d);
        chk("R6 unknown opcode stored nothing", d, 8'h3C);
    endtask

    task automatic t_partial();
        logic [7:0] d;
        wr1(16'h0100, 8'hAA);
        sel();
        send_hdr(OP_WR, 16'h0100);
        xfer(8'h55, 5, d);
        desel();
        rd1(16'h0100, d);
        chk("R7 partial byte not stored", d, 8'hAA);
    endtask

    task automatic t_oe_phases();
        logic [7:0] d;
        sel();
        chk("R8 oe low after select", {7'd0, spi_so_oe}, 8'h00);
        xfer(OP_RD, 8, d);
        xfer(8'h12, 8, d);
        chk("R8 oe low in address phase", {7'd0, spi_so_oe}, 8'h00);
        xfer(8'h34, 8, d);
        xfer(8'h00, 8, d);
        chk("R2 read phase byte", d, 8'hC5);
        desel();
        sel();
        send_hdr(OP_WR, 16'h0300);
        xfer(8'h0F, 8, d);
        chk("R8 oe low in write data", {7'd0, spi_so_oe}, 8'h00);
        desel();
    endtask

    task automatic t_abort();
        logic [7:0] d;
        sel();
        xfer(OP_RD, 3, d);
        desel();
        wr1(16'h0300, 8'h5A);
        rd1(16'h0300, d);
        chk("R9 fresh opcode after mid-opcode abort", d, 8'h5A);
        sel();
        xfer(OP_WR, 8, d);
        xfer(8'h03, 8, d);
        desel();
        wr1(16'h0301, 8'h6B);
        rd1(16'h0301, d);
        chk("R9 fresh opcode after mid-address abort", d, 8'h6B);
        rd1(16'h0300, d);
        chk("R9 aborted command left 0x0300", d, 8'h5A);
    endtask

    task automatic t_alias();
        logic [7:0] d;
        wr1(16'h0005, 8'hE1);
        rd1(16'h0405, d);
        chk("R10 0x0405 aliases 0x0005", d, 8'hE1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_wrap();
        t_bad_opcode();
        t_partial();
        t_oe_phases();
        t_abort();
        t_alias();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule